// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Line-Break Detection

This block turns an asynchronous serial line into parallel characters. It watches the line on the cycles where a sample enable is high. In the normal mode that enable runs at sixteen times the bit rate. A direct mode takes one sample per bit instead. Character length, parity treatment and a compare value come from static configuration inputs. Each finished character is held on the output with its error and match flags until the consumer takes it.

The receiver rejects start bits that turn out to be noise. After a bad stop bit it waits half a bit before it looks for a new start bit again. A held-low line is reported as one break character, followed by a break-start event and, once the line recovers, a break-end event. Configuration must not change while a character is being received or held.

Top module: `asyncRx`

## Requirements
- R1: Character length is 5 + `cfgCharLen` bits (0 gives 5, 3 gives 8). Bits arrive least significant first and are presented right-justified on `rxData`, with every bit above the length read as zero.
- R2: `cfgParity` selects parity treatment: 0 none (no parity bit on the line), 1 even, 2 odd, 3 forced. In forced mode the received parity bit must equal `cfgForceLvl`. A mismatch sets `rxParityErr` with the character.
- R3: In 16X mode a low sample starts a start-bit check. The start is confirmed on the 8th enabled sample counted from that first low one, and every later bit is sampled 16 enabled samples after the previous one.
- R4: A start bit that has returned high by its confirming sample is dropped: no character is produced, and the receiver waits for the next low sample.
- R5: A low stop-bit sample sets `rxFrameErr` with the character. In 16X mode the search for a new start bit resumes 8 enabled samples after the stop sample, so a start bit that follows the bad stop bit directly is decoded correctly.
- R6: A character whose data bits and stop bit are all zero is delivered once with `rxFrameErr` set, and `breakStartEvt` pulses for one cycle in the same cycle. No further character is produced while the line stays low.
- R7: After a break, the first enabled sample that finds the line high makes `breakEndEvt` pulse for one cycle, and reception resumes normally.
- R8: If a character completes while the previous one is still valid and not being taken in that cycle, `overrunEvt` pulses for one cycle and the new character replaces the old one.
- R9: `rxMatch` is set with a character when its data equals the low character-length bits of `cfgMatchChar`.
- R10: With `cfgX16` low, each enabled sample is one bit period. A low sample is taken as the start bit at once, the following samples are the data bits, parity bit and stop bit, and there is no half-bit wait after a framing error.
- R11: After reset `rxValid` and all event outputs are low. A delivered character keeps `rxValid` high and its fields stable until a cycle with `rxTake` high, which clears `rxValid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Sample enable (16x or 1x bit rate) |
| rxLine | input | 1 | Serial input line, idle high |
| cfgX16 | input | 1 | 1: sixteen samples per bit, 0: one sample per bit |
| cfgCharLen | input | 2 | Character length select, length = 5 + value |
| cfgParity | input | 2 | Parity treatment: 0 none, 1 even, 2 odd, 3 forced |
| cfgForceLvl | input | 1 | Expected parity level in forced mode |
| cfgMatchChar | input | 8 | Compare value for the match flag |
| rxTake | input | 1 | Consumer takes the held character |
| rxValid | output | 1 | A received character is held |
| rxData | output | 8 | Received character, right-justified |
| rxParityErr | output | 1 | Parity error of the held character |
| rxFrameErr | output | 1 | Stop bit of the held character was low |
| rxMatch | output | 1 | Held character equals the compare value |
| overrunEvt | output | 1 | One-cycle pulse: a held character was overwritten |
| breakStartEvt | output | 1 | One-cycle pulse: line break detected |
| breakEndEvt | output | 1 | One-cycle pulse: line returned high after a break |

## Verification
If the sample phase or the bit counter is wrong, the data and flags of the very next character are wrong. That happens by the stop-bit sample, within one character time. If the half-bit wait after a framing error is wrong, the start bit that follows the bad stop bit is taken half a bit off, and the character after it comes out shifted. If the break state is wrong, extra zero characters appear while the line is held low, or the end-of-break pulse is missing once the line goes high. Overrun and handshake faults show up as a missing pulse or a lost character on the second of two untaken characters.

// File: rtl/asyncRxPkg.sv
package asyncRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4,
    ST_HOLD   = 3'd5,
    ST_BREAK  = 3'd6
  } rxState_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic clearChar;
    logic shiftBit;
    logic grabParity;
    logic finish;
    logic breakStart;
    logic breakEnd;
  } rxStrobe_t;

  localparam logic [1:0] PAR_NONE  = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_ODD   = 2'd2;
  localparam logic [1:0] PAR_FORCE = 2'd3;

endpackage

// File: rtl/asyncRxCtrl.sv
module asyncRxCtrl
  import asyncRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MIN_BITS   = 5,
  parameter int MAX_BITS   = 8,
  parameter int LEN_SEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 rxBit,
  input  logic                 cfgX16,
  input  logic [LEN_SEL_W-1:0] cfgCharLen,
  input  logic [1:0]           cfgParity,
  input  logic                 charZero,
  output rxStrobe_t            strobe
);

  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int BW   = $clog2(MAX_BITS);
  localparam int MID  = OVERSAMPLE / 2 - 1;
  localparam int LAST = OVERSAMPLE - 1;

  rxState_e      st, stNext;
  logic [CW-1:0] tick, tickNext;
  logic [BW-1:0] bitCnt, bitNext;
  logic [BW-1:0] lenLast;
  logic          tickLast, tickMid, parityOn;

  assign lenLast  = BW'(MIN_BITS - 1) + BW'(cfgCharLen);
  assign parityOn = (cfgParity != PAR_NONE);
  assign tickMid  = (tick == CW'(MID));
  assign tickLast = cfgX16 ? (tick == CW'(LAST)) : 1'b1;

  always_comb begin
    stNext   = st;
    tickNext = tick;
    bitNext  = bitCnt;
    strobe   = '0;
    if (sampleEn) begin
      unique case (st)
        ST_IDLE: begin
          if (!rxBit) begin
            tickNext = '0;
            if (cfgX16) begin
              stNext = ST_START;
            end else begin
              stNext           = ST_DATA;
              bitNext          = '0;
              strobe.clearChar = 1'b1;
            end
          end
        end
        ST_START: begin
          if (tickMid) begin
            tickNext = '0;
            if (!rxBit) begin
              stNext           = ST_DATA;
              bitNext          = '0;
              strobe.clearChar = 1'b1;
            end else begin
              stNext = ST_IDLE;
            end
          end else begin
            tickNext = tick + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickLast) begin
            tickNext        = '0;
            strobe.shiftBit = 1'b1;
            if (bitCnt == lenLast) begin
              stNext = parityOn ? ST_PARITY : ST_STOP;
            end else begin
              bitNext = bitCnt + 1'b1;
            end
          end else begin
            tickNext = tick + 1'b1;
          end
        end
        ST_PARITY: begin
          if (tickLast) begin
            tickNext          = '0;
            strobe.grabParity = 1'b1;
            stNext            = ST_STOP;
          end else begin
            tickNext = tick + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickLast) begin
            tickNext      = '0;
            strobe.finish = 1'b1;
            if (rxBit) begin
              stNext = ST_IDLE;
            end else if (charZero) begin
              strobe.breakStart = 1'b1;
              stNext            = ST_BREAK;
            end else begin
              stNext = cfgX16 ? ST_HOLD : ST_IDLE;
            end
          end else begin
            tickNext = tick + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tickMid) begin
            tickNext = '0;
            stNext   = ST_IDLE;
          end else begin
            tickNext = tick + 1'b1;
          end
        end
        ST_BREAK: begin
          if (rxBit) begin
            strobe.breakEnd = 1'b1;
            stNext          = ST_IDLE;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      tick   <= '0;
      bitCnt <= '0;
    end else begin
      st     <= stNext;
      tick   <= tickNext;
      bitCnt <= bitNext;
    end
  end

endmodule

// File: rtl/asyncRxDatapath.sv
module asyncRxDatapath
  import asyncRxPkg::*;
#(
  parameter int MIN_BITS  = 5,
  parameter int MAX_BITS  = 8,
  parameter int LEN_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxBit,
  input  rxStrobe_t            strobe,
  input  logic [LEN_SEL_W-1:0] cfgCharLen,
  input  logic [1:0]           cfgParity,
  input  logic                 cfgForceLvl,
  input  logic [MAX_BITS-1:0]  cfgMatchChar,
  input  logic                 rxTake,
  output logic                 charZero,
  output logic                 rxValid,
  output logic [MAX_BITS-1:0]  rxData,
  output logic                 rxParityErr,
  output logic                 rxFrameErr,
  output logic                 rxMatch,
  output logic                 overrunEvt,
  output logic                 breakStartEvt,
  output logic                 breakEndEvt
);

  localparam int LW = $clog2(MAX_BITS + 1);

  logic [MAX_BITS-1:0] shiftReg;
  logic                parBit;
  logic [LW-1:0]       curLen;
  logic [MAX_BITS-1:0] lenMask, alignedChar;
  logic                dataOnes, parityBad;

  assign curLen      = LW'(MIN_BITS) + LW'(cfgCharLen);
  assign lenMask     = ~({MAX_BITS{1'b1}} << curLen);
  // bits enter at the top, so the finished character sits in the upper end
  assign alignedChar = shiftReg >> (LW'(MAX_BITS) - curLen);
  assign dataOnes    = ^alignedChar;
  assign charZero    = (shiftReg == '0);

  always_comb begin
    unique case (cfgParity)
      PAR_EVEN:  parityBad = dataOnes ^ parBit;
      PAR_ODD:   parityBad = ~(dataOnes ^ parBit);
      PAR_FORCE: parityBad = parBit ^ cfgForceLvl;
      default:   parityBad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.clearChar) begin
        shiftReg <= '0;
      end else if (strobe.shiftBit) begin
        shiftReg <= {rxBit, shiftReg[MAX_BITS-1:1]};
      end
      if (strobe.grabParity) begin
        parBit <= rxBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid       <= 1'b0;
      rxData        <= '0;
      rxParityErr   <= 1'b0;
      rxFrameErr    <= 1'b0;
      rxMatch       <= 1'b0;
      overrunEvt    <= 1'b0;
      breakStartEvt <= 1'b0;
      breakEndEvt   <= 1'b0;
    end else begin
      overrunEvt    <= 1'b0;
      breakStartEvt <= strobe.breakStart;
      breakEndEvt   <= strobe.breakEnd;
      if (strobe.finish) begin
        rxValid     <= 1'b1;
        rxData      <= alignedChar;
        rxParityErr <= parityBad;
        rxFrameErr  <= ~rxBit;
        rxMatch     <= (alignedChar == (cfgMatchChar & lenMask));
        overrunEvt  <= rxValid & ~rxTake;
      end else if (rxTake) begin
        rxValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/asyncRx.sv
module asyncRx
  import asyncRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MIN_BITS   = 5,
  parameter int MAX_BITS   = 8,
  parameter int LEN_SEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 rxLine,
  input  logic                 cfgX16,
  input  logic [LEN_SEL_W-1:0] cfgCharLen,
  input  logic [1:0]           cfgParity,
  input  logic                 cfgForceLvl,
  input  logic [MAX_BITS-1:0]  cfgMatchChar,
  input  logic                 rxTake,
  output logic                 rxValid,
  output logic [MAX_BITS-1:0]  rxData,
  output logic                 rxParityErr,
  output logic                 rxFrameErr,
  output logic                 rxMatch,
  output logic                 overrunEvt,
  output logic                 breakStartEvt,
  output logic                 breakEndEvt
);

  rxStrobe_t strobe;
  logic      charZero;

  asyncRxCtrl #(
    .OVERSAMPLE(OVERSAMPLE), .MIN_BITS(MIN_BITS),
    .MAX_BITS(MAX_BITS), .LEN_SEL_W(LEN_SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxBit(rxLine),
    .cfgX16(cfgX16), .cfgCharLen(cfgCharLen), .cfgParity(cfgParity),
    .charZero(charZero), .strobe(strobe)
  );

  asyncRxDatapath #(
    .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LEN_SEL_W(LEN_SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxLine), .strobe(strobe),
    .cfgCharLen(cfgCharLen), .cfgParity(cfgParity),
    .cfgForceLvl(cfgForceLvl), .cfgMatchChar(cfgMatchChar),
    .rxTake(rxTake), .charZero(charZero), .rxValid(rxValid),
    .rxData(rxData), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rxMatch(rxMatch), .overrunEvt(overrunEvt),
    .breakStartEvt(breakStartEvt), .breakEndEvt(breakEndEvt)
  );

endmodule

// File: rtl/asyncRxChecker.sv
module asyncRxChecker #(
  parameter int MIN_BITS  = 5,
  parameter int MAX_BITS  = 8,
  parameter int LEN_SEL_W = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleEn,
  input logic                 rxLine,
  input logic [LEN_SEL_W-1:0] cfgCharLen,
  input logic                 rxTake,
  input logic                 rxValid,
  input logic [MAX_BITS-1:0]  rxData,
  input logic                 rxFrameErr,
  input logic                 overrunEvt,
  input logic                 breakStartEvt,
  input logic                 breakEndEvt
);

  localparam int LW = $clog2(MAX_BITS + 1);
  logic [LW-1:0]       chkLen;
  logic [MAX_BITS-1:0] upperBits;
  assign chkLen    = LW'(MIN_BITS) + LW'(cfgCharLen);
  assign upperBits = {MAX_BITS{1'b1}} << chkLen;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData & upperBits) == '0));

  assert_valid_after_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(sampleEn));

  assert_break_char_R6: assert property (@(posedge clk) disable iff (!rstN)
    breakStartEvt |-> (rxValid && rxFrameErr && rxData == '0));

  assert_break_end_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    breakEndEvt |-> ($past(rxLine) && $past(sampleEn)));

  assert_break_events_apart_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(breakStartEvt && breakEndEvt));

  assert_overrun_holds_char_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrunEvt |-> rxValid);

  assert_valid_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxTake) |=> rxValid);

endmodule

bind asyncRx asyncRxChecker #(
  .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .LEN_SEL_W(LEN_SEL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxLine(rxLine),
  .cfgCharLen(cfgCharLen), .rxTake(rxTake), .rxValid(rxValid),
  .rxData(rxData), .rxFrameErr(rxFrameErr), .overrunEvt(overrunEvt),
  .breakStartEvt(breakStartEvt), .breakEndEvt(breakEndEvt)
);

// File: tb/sim_asyncRx.sv
`timescale 1ns/1ps
module sim_asyncRx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic       rxLine = 1'b1;
  logic       cfgX16 = 1'b1;
  logic [1:0] cfgCharLen = 2'd3;
  logic [1:0] cfgParity = 2'd0;
  logic       cfgForceLvl = 1'b0;
  logic [7:0] cfgMatchChar = 8'h00;
  logic       rxTake = 1'b0;
  logic       rxValid, rxParityErr, rxFrameErr, rxMatch;
  logic [7:0] rxData;
  logic       overrunEvt, breakStartEvt, breakEndEvt;

  int checks = 0;
  int fails = 0;
  int nBrkStart = 0;
  int nBrkEnd = 0;
  int nOverrun = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  asyncRx u0 (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxLine(rxLine),
    .cfgX16(cfgX16), .cfgCharLen(cfgCharLen), .cfgParity(cfgParity),
    .cfgForceLvl(cfgForceLvl), .cfgMatchChar(cfgMatchChar), .rxTake(rxTake),
    .rxValid(rxValid), .rxData(rxData), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .rxMatch(rxMatch), .overrunEvt(overrunEvt),
    .breakStartEvt(breakStartEvt), .breakEndEvt(breakEndEvt)
  );

  always @(negedge clk) begin
    if (breakStartEvt) nBrkStart++;
    if (breakEndEvt)   nBrkEnd++;
    if (overrunEvt)    nOverrun++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one enabled sample with the line at lvl
  task automatic tick(input logic lvl);
    @(negedge clk);
    rxLine   = lvl;
    sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
  endtask

  task automatic holdBit(input logic lvl, input int n);
    for (int i = 0; i < n; i++) tick(lvl);
  endtask

  function automatic int bitTicks();
    return cfgX16 ? 16 : 1;
  endfunction

  function automatic int lenOf();
    return 5 + int'(cfgCharLen);
  endfunction

  function automatic logic [7:0] maskOf(input int len);
    return 8'((1 << len) - 1);
  endfunction

  function automatic logic goodParity(input logic [7:0] d);
    logic ones = ^(d & maskOf(lenOf()));
    case (cfgParity)
      2'd1:    return ones;
      2'd2:    return ~ones;
      2'd3:    return cfgForceLvl;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sendChar(input logic [7:0] d, input logic pbit, input logic stopLvl);
    holdBit(1'b0, bitTicks());
    for (int i = 0; i < lenOf(); i++) holdBit(d[i], bitTicks());
    if (cfgParity != 2'd0) holdBit(pbit, bitTicks());
    holdBit(stopLvl, bitTicks());
  endtask

  task automatic takeChar();
    @(negedge clk);
    rxTake = 1'b1;
    @(negedge clk);
    rxTake = 1'b0;
  endtask

  task automatic checkChar(input string tag, input logic [7:0] d, input logic pe,
                           input logic fe, input logic mt);
    check({tag, " valid"}, rxValid, 1'b1);
    check({tag, " data"}, rxData, d & maskOf(lenOf()));
    check({tag, " parity"}, rxParityErr, pe);
    check({tag, " frame"}, rxFrameErr, fe);
    check({tag, " match"}, rxMatch, mt);
    takeChar();
    check({tag, " R11 cleared"}, rxValid, 1'b0);
  endtask

  function automatic logic expMatch(input logic [7:0] d);
    return (d & maskOf(lenOf())) == (cfgMatchChar & maskOf(lenOf()));
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int prevOv;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset valid", rxValid, 1'b0);
    check("R11 reset events", {overrunEvt, breakStartEvt, breakEndEvt}, 3'b000);
    holdBit(1'b1, 20);

    // R1 eight-bit character, no parity
    sendChar(8'hA5, 1'b0, 1'b1);
    holdBit(1'b1, 3);
    checkChar("R1 8bit", 8'hA5, 1'b0, 1'b0, expMatch(8'hA5));

    // R4 short glitch; R3 seven low samples are still not a start
    holdBit(1'b0, 4);
    holdBit(1'b1, 200);
    check("R4 glitch ignored", rxValid, 1'b0);
    holdBit(1'b0, 7);
    holdBit(1'b1, 200);
    check("R3 seven-sample low ignored", rxValid, 1'b0);
    sendChar(8'h3C, 1'b0, 1'b1);
    checkChar("R4 after false start", 8'h3C, 1'b0, 1'b0, expMatch(8'h3C));

    // R5 bad stop then start bit immediately after
    sendChar(8'h5A, 1'b0, 1'b0);
    checkChar("R5 framing", 8'h5A, 1'b0, 1'b1, expMatch(8'h5A));
    sendChar(8'h81, 1'b0, 1'b1);
    checkChar("R5 resume half bit", 8'h81, 1'b0, 1'b0, expMatch(8'h81));
    check("R5 no break", nBrkStart, 0);
    holdBit(1'b1, 16);

    // R6/R7 line held low
    holdBit(1'b0, 16 * 10);
    check("R6 break start", nBrkStart, 1);
    check("R7 no end yet", nBrkEnd, 0);
    checkChar("R6 break char", 8'h00, 1'b0, 1'b1, expMatch(8'h00));
    holdBit(1'b0, 16 * 20);
    check("R6 single break char", rxValid, 1'b0);
    check("R7 still low", nBrkEnd, 0);
    holdBit(1'b1, 16);
    check("R7 break end", nBrkEnd, 1);
    check("R6 one start", nBrkStart, 1);
    sendChar(8'h42, 1'b0, 1'b1);
    checkChar("R7 resume", 8'h42, 1'b0, 1'b0, expMatch(8'h42));

    // R8 overrun
    prevOv = nOverrun;
    sendChar(8'h11, 1'b0, 1'b1);
    check("R8 first no overrun", nOverrun, prevOv);
    sendChar(8'h22, 1'b0, 1'b1);
    check("R8 overrun pulse", nOverrun, prevOv + 1);
    checkChar("R8 newest kept", 8'h22, 1'b0, 1'b0, expMatch(8'h22));

    // R9 match at five bits, compare value upper bits ignored
    cfgCharLen   = 2'd0;
    cfgMatchChar = 8'hF3;
    sendChar(8'h13, 1'b0, 1'b1);
    checkChar("R9 match", 8'h13, 1'b0, 1'b0, 1'b1);
    sendChar(8'h12, 1'b0, 1'b1);
    checkChar("R9 no match", 8'h12, 1'b0, 1'b0, 1'b0);

    // R2 forced parity
    cfgCharLen  = 2'd2;
    cfgParity   = 2'd3;
    cfgForceLvl = 1'b1;
    sendChar(8'h55, 1'b1, 1'b1);
    checkChar("R2 forced ok", 8'h55, 1'b0, 1'b0, expMatch(8'h55));
    sendChar(8'h55, 1'b0, 1'b1);
    checkChar("R2 forced bad", 8'h55, 1'b1, 1'b0, expMatch(8'h55));

    // R10 one sample per bit
    cfgX16    = 1'b0;
    cfgParity = 2'd1;
    cfgCharLen = 2'd3;
    holdBit(1'b1, 4);
    sendChar(8'hC3, goodParity(8'hC3), 1'b1);
    checkChar("R10 1x even", 8'hC3, 1'b0, 1'b0, expMatch(8'hC3));
    sendChar(8'h6E, goodParity(8'h6E), 1'b0);
    checkChar("R10 1x framing", 8'h6E, 1'b0, 1'b1, expMatch(8'h6E));
    sendChar(8'h0F, goodParity(8'h0F), 1'b1);
    checkChar("R10 1x no wait", 8'h0F, 1'b0, 1'b0, expMatch(8'h0F));

    // random frames, both clock factors
    for (int n = 0; n < 70; n++) begin
      logic [7:0] d;
      logic pb, flip;
      cfgX16      = (n < 45);
      cfgCharLen  = 2'($urandom_range(0, 3));
      cfgParity   = 2'($urandom_range(0, 3));
      cfgForceLvl = 1'($urandom_range(0, 1));
      d           = 8'($urandom);
      cfgMatchChar = ($urandom_range(0, 3) == 0) ? d : 8'($urandom);
      flip        = ($urandom_range(0, 3) == 0) && (cfgParity != 2'd0);
      pb          = goodParity(d) ^ flip;
      holdBit(1'b1, $urandom_range(1, 3) * bitTicks());
      sendChar(d, pb, 1'b1);
      checkChar(cfgX16 ? "R2 R1 random 16x" : "R10 R2 random 1x", d, flip, 1'b0, expMatch(d));
    end

    summary();
  end

endmodule